// File: doc/BRIEF.md
# Framed Four-Bit Pattern Recognizer

The block reads a serial bit stream one bit per strobed cycle and groups the bits into back-to-back frames of four, counted from reset. On the last bit of every frame it raises its match output for that cycle alone, provided the frame as a whole spells one of two accepted patterns. The frames never overlap: once a frame's last bit is taken, the next strobed bit opens a new frame, whatever the previous bits were.

Inside, a seven-state machine holds the frame progress. Prefixes that lead to the same outcome share a state. A three-bit code with paired states at adjacent codes holds that state. The match output is a Mealy function of the current state, the bit in the current cycle and the strobe, so it appears in the same cycle as the bit that completes the frame. Cycles without the strobe leave the frame position unchanged.

Top module: `frame_rec`

## Requirements
- R1: While `rst_ni` is low, `z_o` is 0. The first strobed bit after reset is the first bit of a new frame, even if reset cut a frame short.
- R2: In a cycle with `valid_i` low, `z_o` is 0 and the frame position and collected bits stay unchanged, whatever `x_i` is.
- R3: `z_o` is 1 on the fourth strobed bit of a frame whose bits, in arrival order, are 1,0,1,0.
- R4: `z_o` is 1 on the fourth strobed bit of a frame whose bits, in arrival order, are 0,1,1,0.
- R5: `z_o` is 0 on the first three bits of every frame, and on the fourth bit of each of the other fourteen frames.
- R6: Frames do not overlap. The strobed bit after a frame's fourth bit is always the first bit of the next frame, whether or not the previous frame matched.
- R7: `z_o` is combinational in `x_i`. When the first three bits of a frame are 1,0,1 or 0,1,1, `z_o` follows the inverse of `x_i` within the fourth-bit cycle.
- R8: The 20-bit stream 0010 0110 1100 1010 0011, with the leftmost bit first, gives `z_o` = 0000 0001 0000 0001 0000 across those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bit strobe; `x_i` is taken only when high |
| x_i | input | 1 | Serial data bit |
| z_o | output | 1 | Match flag for the frame completed in this cycle |

## Verification
Two things happen in the same cycle: a frame completes with a match, and the machine wraps to the start of the next frame. The bench provokes this by sending matching frames back to back with no idle cycle, and checks that the next frame is decoded from a clean start. Idle cycles are also placed immediately before the fourth bit. The bench then checks that the frame still completes on the next strobed bit and that `z_o` stays low while the strobe is low.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int unsigned ST_W = 3;

  // paired prefixes sit on adjacent codes; 3'b100 is unused
  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'b000,
    ST_B0   = 3'b001,
    ST_B1   = 3'b101,
    ST_SAME = 3'b011,
    ST_DIFF = 3'b111,
    ST_DEAD = 3'b010,
    ST_HIT  = 3'b110
  } state_t;
endpackage

// File: rtl/frm_next.sv
module frm_next
  import frm_pkg::*;
(
  input  state_t cur_i,
  input  logic   x_i,
  output state_t nxt_o
);
  always_comb begin
    case (cur_i)
      ST_IDLE: nxt_o = x_i ? ST_B1 : ST_B0;
      ST_B0:   nxt_o = x_i ? ST_DIFF : ST_SAME;
      ST_B1:   nxt_o = x_i ? ST_SAME : ST_DIFF;
      ST_SAME: nxt_o = ST_DEAD;
      ST_DIFF: nxt_o = x_i ? ST_HIT : ST_DEAD;
      ST_DEAD: nxt_o = ST_IDLE;
      ST_HIT:  nxt_o = ST_IDLE;
      default: nxt_o = ST_IDLE; // unused code recovers
    endcase
  end
endmodule

// File: rtl/frm_out.sv
module frm_out
  import frm_pkg::*;
(
  input  state_t cur_i,
  input  logic   valid_i,
  input  logic   x_i,
  output logic   z_o
);
  always_comb z_o = valid_i && (cur_i == ST_HIT) && !x_i;
endmodule

// File: rtl/frm_state_reg.sv
module frm_state_reg
  import frm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  state_t d_i,
  output state_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= ST_IDLE;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/frame_rec.sv
module frame_rec
  import frm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic x_i,
  output logic z_o
);
  state_t state_q;
  state_t state_d;

  frm_next u_next (
    .cur_i (state_q),
    .x_i   (x_i),
    .nxt_o (state_d)
  );

  frm_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  frm_out u_out (
    .cur_i   (state_q),
    .valid_i (valid_i),
    .x_i     (x_i),
    .z_o     (z_o)
  );
endmodule

// File: rtl/frame_rec_chk.sv
module frame_rec_chk
  import frm_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   valid_i,
  input logic   x_i,
  input logic   z_o,
  input state_t state_i
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !z_o);

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_i));

  assert_frame_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (state_i == ST_DEAD || state_i == ST_HIT) |=> state_i == ST_IDLE);

  assert_match_ends_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o |=> state_i == ST_IDLE);

  assert_first_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && state_i == ST_IDLE |=> (state_i == ST_B0 || state_i == ST_B1));

  assert_mealy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o |-> valid_i && !x_i);

  always_comb
    if (!rst_ni) assert_reset_quiet_R1: assert (!z_o);
endmodule

bind frame_rec frame_rec_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .x_i     (x_i),
  .z_o     (z_o),
  .state_i (state_q)
);

// File: tb/frame_rec_bench.sv
`timescale 1ns/1ps
module frame_rec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic x = 1'b0;
  logic z;

  int checks = 0;
  int fails = 0;
  int pos = 0;
  logic [2:0] sh = 3'b000;

  always #5 clk = ~clk;

  frame_rec u_frame_rec (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (valid),
    .x_i     (x),
    .z_o     (z)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: z_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic hit(input logic [3:0] f);
    return (f == 4'b1010) || (f == 4'b0110);
  endfunction

  task automatic send(input logic b, input string tag);
    logic exp;
    string req;
    @(negedge clk);
    valid = 1'b1;
    x = b;
    #2;
    exp = (pos == 3) && hit({sh, b});
    if (tag != "") req = tag;
    else if (pos != 3) req = "R5";
    else if ({sh, b} == 4'b1010) req = "R3";
    else if ({sh, b} == 4'b0110) req = "R4";
    else req = "R5";
    chk(z, exp, req);
    sh = {sh[1:0], b};
    pos = (pos == 3) ? 0 : pos + 1;
  endtask

  task automatic idle(input logic b);
    @(negedge clk);
    valid = 1'b0;
    x = b;
    #2;
    chk(z, 1'b0, "R2");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    valid = 1'b1;
    x = 1'b0;
    #2;
    chk(z, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    valid = 1'b0;
    pos = 0;
    sh = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] stim;
    logic [19:0] zexp;
    #2;
    chk(z, 1'b0, "R1");
    do_reset();

    // all frames, with an idle gap before each bit position (gp==4: none)
    for (int gp = 0; gp < 5; gp++) begin
      for (int f = 0; f < 16; f++) begin
        for (int k = 3; k >= 0; k--) begin
          if (gp == 3 - k) begin
            idle(1'b0);
            idle(1'b1);
          end
          send(f[k], "");
        end
      end
    end

    // back-to-back matches: next frame must decode from a clean start
    send(1'b1, ""); send(1'b0, ""); send(1'b1, ""); send(1'b0, "R6");
    send(1'b0, ""); send(1'b1, ""); send(1'b1, ""); send(1'b0, "R6");
    send(1'b1, ""); send(1'b0, ""); send(1'b1, ""); send(1'b1, "R6");
    send(1'b1, "R6");

    // reset cuts a frame short; then a full match from bit zero
    do_reset();
    send(1'b1, ""); send(1'b0, ""); send(1'b1, ""); send(1'b0, "R1");

    // same-cycle response to x on the closing bit
    for (int p = 0; p < 2; p++) begin
      if (p == 0) begin
        send(1'b1, ""); send(1'b0, ""); send(1'b1, "");
      end else begin
        send(1'b0, ""); send(1'b1, ""); send(1'b1, "");
      end
      @(negedge clk);
      valid = 1'b1;
      x = 1'b1;
      #1 chk(z, 1'b0, "R7");
      x = 1'b0;
      #1 chk(z, 1'b1, "R7");
      x = 1'b1;
      #1 chk(z, 1'b0, "R7");
      x = 1'b0;
      #1 chk(z, 1'b1, "R7");
      sh = {sh[1:0], 1'b0};
      pos = 0;
    end

    // example stream, leftmost bit first
    stim = 20'b0010_0110_1100_1010_0011;
    zexp = 20'b0000_0001_0000_0001_0000;
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk);
      valid = 1'b1;
      x = stim[i];
      #2;
      chk(z, zexp[i], "R8");
    end

    @(negedge clk);
    valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule